// File: doc/BRIEF.md
# Sleep-Depth Clock Gate Controller

This block decides which of three clock-related enables are active around a processor core: the core clock, the peripheral clock and the oscillator. Software asks for sleep by writing a control strobe that carries two request bits, one for light sleep and one for deep sleep. Light sleep stops only the core clock. Peripherals, the oscillator and the external interrupt lines keep running, and any active interrupt ends the sleep. Deep sleep also stops the peripheral clock and the oscillator. Only a reset, or an external line that was enabled when deep sleep began, can end it.

After a deep-sleep wake the oscillator is switched back on first. The clocks stay off while a startup counter counts pulses of a free-running slow reference. The default of 328 pulses is about 10 ms at 32.768 kHz. Every wake passes through one resume cycle, in which the wake has been registered but the core clock is still off. Both request bits clear when the core clock comes back on.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset (active low, taking effect without a clock edge) sets the core, peripheral and oscillator enables to 1 and both request flags to 0. Reset also overrides deep sleep.
- R2: In run mode, a write with only the light bit (`cfg_wr_light`) set gives this state from the next cycle: core enable 0, peripheral and oscillator enables 1, light flag 1.
- R3: In run mode, a write with the deep bit (`cfg_wr_deep`) set turns all three enables off from the next cycle and sets the deep flag. When both bits are written together, deep sleep wins and both flags read 1.
- R4: Light sleep ends on any `irq_req` bit, or on an `ext_irq` line whose `ext_irq_en` bit is set at that moment. Masked external lines and slow-reference pulses do not end it.
- R5: A wake sampled at clock edge k produces a resume state from edge k: core enable 0, peripheral and oscillator enables 1, flags unchanged. From edge k+1 the core enable is 1 and both flags are 0.
- R6: Deep sleep ends only on an `ext_irq` line whose `ext_irq_en` bit was 1 at the write that entered deep sleep. `irq_req` has no effect. Lines enabled only after entry have no effect.
- R7: After a deep-sleep wake the oscillator enable is 1 and the core and peripheral enables stay 0 until `WARMUP_TICKS` slow-reference pulses have been counted. Pulses seen before the wake do not count. The edge that samples the last pulse enters the resume state.
- R8: Writes made outside run mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| cfg_wr_en | input | 1 | Strobe for a power-control write |
| cfg_wr_light | input | 1 | Light-sleep request bit of the write |
| cfg_wr_deep | input | 1 | Deep-sleep request bit of the write |
| irq_req | input | NUM_IRQ | Interrupt requests from running sources |
| ext_irq | input | NUM_EXT | External interrupt lines |
| ext_irq_en | input | NUM_EXT | Enables for the external lines |
| ref_tick | input | 1 | One-cycle pulse from the slow reference |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| light_flag | output | 1 | Light-sleep request bit as stored |
| deep_flag | output | 1 | Deep-sleep request bit as stored |

## Verification
A sleep request shows at the outputs one edge after the write. A wake shows as the resume state one edge after it is sampled, and as a running core one edge after that. The deep-sleep resume follows the edge that samples the final reference pulse. The bench drives every input just after a falling edge and queues the outputs expected after the next rising edge. A monitor compares the queued values 1 ns after each rising edge, so every comparison lands in the cycle where that result is due. Reset is checked between edges, because it acts without a clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_LIGHT  = 3'd1,
    PM_DEEP   = 3'd2,
    PM_WARMUP = 3'd3,
    PM_RESUME = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
  parameter int NUM_IRQ = 4,
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snap_load,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  output logic               light_wake,
  output logic               deep_wake,
  output logic [NUM_EXT-1:0] snap_en
);
  logic [NUM_EXT-1:0] snap_d, snap_q;
  logic [NUM_EXT-1:0] live_hit, kept_hit;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
    assign live_hit[g] = ext_irq[g] & ext_irq_en[g];
    assign kept_hit[g] = ext_irq[g] & snap_q[g];
  end

  always_comb begin
    snap_d = snap_q;
    if (snap_load) snap_d = ext_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign light_wake = (|irq_req) | (|live_hit);
  assign deep_wake  = |kept_hit;
  assign snap_en    = snap_q;
endmodule

// File: rtl/pmc_warmup_timer.sv
module pmc_warmup_timer #(
  parameter int TICKS = 328
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ref_tick,
  output logic done
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign done = active & ref_tick & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)                cnt_d = '0;
    else if (ref_tick && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_light,
  input  logic      wr_deep,
  input  logic      light_wake,
  input  logic      deep_wake,
  input  logic      warm_done,
  output pm_state_e state,
  output logic      light_bit,
  output logic      deep_bit,
  output logic      snap_load,
  output logic      warm_active
);
  pm_state_e state_d, state_q;
  logic light_d, light_q, deep_d, deep_q;
  logic run_wr;

  assign run_wr = (state_q == PM_RUN) & wr_en & (wr_light | wr_deep);

  always_comb begin
    state_d = state_q;
    light_d = light_q;
    deep_d  = deep_q;
    unique case (state_q)
      PM_RUN: begin
        if (run_wr) begin
          light_d = wr_light;
          deep_d  = wr_deep;
          state_d = wr_deep ? PM_DEEP : PM_LIGHT;
        end
      end
      PM_LIGHT:  if (light_wake) state_d = PM_RESUME;
      PM_DEEP:   if (deep_wake)  state_d = PM_WARMUP;
      PM_WARMUP: if (warm_done)  state_d = PM_RESUME;
      PM_RESUME: begin
        state_d = PM_RUN;
        light_d = 1'b0;
        deep_d  = 1'b0;
      end
      default:   state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      light_q <= 1'b0;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      light_q <= light_d;
      deep_q  <= deep_d;
    end
  end

  assign state       = state_q;
  assign light_bit   = light_q;
  assign deep_bit    = deep_q;
  assign snap_load   = run_wr & wr_deep;
  assign warm_active = (state_q == PM_WARMUP);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ      = 4,
  parameter int NUM_EXT      = 2,
  parameter int WARMUP_TICKS = 328
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic               cfg_wr_light,
  input  logic               cfg_wr_deep,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  input  logic               ref_tick,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic               light_flag,
  output logic               deep_flag
);
  logic [1:0] rst_pipe;
  logic       irst_n;
  logic       light_wake, deep_wake, warm_done, warm_active, snap_load;
  logic [NUM_EXT-1:0] snap_en;
  pm_state_e  state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign irst_n = rst_pipe[1];

  pmc_wake_detect #(.NUM_IRQ(NUM_IRQ), .NUM_EXT(NUM_EXT)) u_wake (
    .clk        (clk),
    .rst_n      (irst_n),
    .snap_load  (snap_load),
    .irq_req    (irq_req),
    .ext_irq    (ext_irq),
    .ext_irq_en (ext_irq_en),
    .light_wake (light_wake),
    .deep_wake  (deep_wake),
    .snap_en    (snap_en)
  );

  pmc_warmup_timer #(.TICKS(WARMUP_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (irst_n),
    .active   (warm_active),
    .ref_tick (ref_tick),
    .done     (warm_done)
  );

  pmc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (irst_n),
    .wr_en       (cfg_wr_en),
    .wr_light    (cfg_wr_light),
    .wr_deep     (cfg_wr_deep),
    .light_wake  (light_wake),
    .deep_wake   (deep_wake),
    .warm_done   (warm_done),
    .state       (state),
    .light_bit   (light_flag),
    .deep_bit    (deep_flag),
    .snap_load   (snap_load),
    .warm_active (warm_active)
  );

  assign cpu_clk_en = (state == PM_RUN);
  assign per_clk_en = (state == PM_RUN) | (state == PM_LIGHT) | (state == PM_RESUME);
  assign osc_en     = (state != PM_DEEP);
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NUM_EXT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_clk_en,
  input logic               per_clk_en,
  input logic               osc_en,
  input logic               light_flag,
  input logic               deep_flag,
  input logic [NUM_EXT-1:0] ext_irq,
  input logic [NUM_EXT-1:0] snap_en
);
  // R2
  light_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_clk_en) && !deep_flag) |-> (light_flag && per_clk_en && osc_en));

  // R5
  resume_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(per_clk_en && osc_en && !cpu_clk_en));

  // R6
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !(|(ext_irq & snap_en))) |=> !osc_en);

  // R7
  osc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (!cpu_clk_en && !per_clk_en));

  // R8
  no_late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !deep_flag) |=> !deep_flag);
endmodule

bind pwr_mode_ctrl pmc_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .light_flag (light_flag),
  .deep_flag  (deep_flag),
  .ext_irq    (ext_irq),
  .snap_en    (snap_en)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int NI = 3;
  localparam int NE = 2;
  localparam int WT = 5;
  // vector order {cpu, per, osc, light, deep}
  localparam logic [4:0] RUNV  = 5'b11100;
  localparam logic [4:0] LITV  = 5'b01110;
  localparam logic [4:0] DEEPV = 5'b00001;
  localparam logic [4:0] BOTHV = 5'b00011;
  localparam logic [4:0] WARMV = 5'b00101;
  localparam logic [4:0] DRESV = 5'b01101;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_light, wr_deep, ref_tick;
  logic [NI-1:0] irq_req;
  logic [NE-1:0] ext_irq, ext_irq_en;
  logic cpu_clk_en, per_clk_en, osc_en, light_flag, deep_flag;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [4:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NI), .NUM_EXT(NE), .WARMUP_TICKS(WT)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_light(wr_light),
    .cfg_wr_deep(wr_deep), .irq_req(irq_req), .ext_irq(ext_irq),
    .ext_irq_en(ext_irq_en), .ref_tick(ref_tick), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .light_flag(light_flag),
    .deep_flag(deep_flag)
  );

  task automatic check(input logic [4:0] exp, input string tag);
    logic [4:0] got;
    got = {cpu_clk_en, per_clk_en, osc_en, light_flag, deep_flag};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic [4:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      check(cur.v, cur.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_light = 1'b0; wr_deep = 1'b0;
    ref_tick = 1'b0; irq_req = '0; ext_irq = '0; ext_irq_en = '0;
    #3 check(RUNV, "R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(RUNV, "R1 after release");

    // light sleep entry
    wr_en = 1'b1; wr_light = 1'b1;
    cyc(LITV, "R2 light entry");
    wr_en = 1'b0; wr_light = 1'b0;
    cyc(LITV, "R2 light held");
    // masked external line ignored
    ext_irq = 2'b10; ext_irq_en = 2'b01;
    cyc(LITV, "R4 masked line");
    cyc(LITV, "R4 masked line");
    // write while asleep ignored
    wr_en = 1'b1; wr_deep = 1'b1;
    cyc(LITV, "R8 write in light");
    wr_en = 1'b0; wr_deep = 1'b0;
    ref_tick = 1'b1;
    cyc(LITV, "R4 tick no wake");
    ref_tick = 1'b0;
    // enabled line wakes, resume cycle then run
    ext_irq = 2'b11;
    cyc(LITV, "R5 resume cycle");
    ext_irq = 2'b00;
    cyc(RUNV, "R5 core back");

    // wake from light via internal request
    wr_en = 1'b1; wr_light = 1'b1;
    cyc(LITV, "R2 light entry 2");
    wr_en = 1'b0; wr_light = 1'b0;
    irq_req = 3'b100;
    cyc(LITV, "R5 resume after irq");
    irq_req = '0;
    cyc(RUNV, "R4 irq wake");

    // deep sleep with line 0 enabled at entry
    ext_irq_en = 2'b01; wr_en = 1'b1; wr_deep = 1'b1;
    cyc(DEEPV, "R3 deep entry");
    wr_en = 1'b0; wr_deep = 1'b0;
    ext_irq_en = 2'b10; ext_irq = 2'b10;
    cyc(DEEPV, "R6 late enable ignored");
    irq_req = 3'b001;
    cyc(DEEPV, "R6 irq_req ignored");
    irq_req = '0; ext_irq = '0;
    ref_tick = 1'b1;
    cyc(DEEPV, "R7 early tick");
    cyc(DEEPV, "R7 early tick");
    ref_tick = 1'b0;
    ext_irq = 2'b01;
    cyc(WARMV, "R6 wake to warmup");
    ext_irq = 2'b00;
    for (int i = 0; i < WT - 1; i++) begin
      ref_tick = 1'b1;
      cyc(WARMV, "R7 counting");
      ref_tick = 1'b0;
      cyc(WARMV, "R7 counting gap");
    end
    ref_tick = 1'b1;
    cyc(DRESV, "R7 last tick resume");
    ref_tick = 1'b0;
    cyc(RUNV, "R5 core back after deep");

    // both bits: deep wins, then reset exits deep sleep
    wr_en = 1'b1; wr_light = 1'b1; wr_deep = 1'b1;
    cyc(BOTHV, "R3 both bits");
    wr_en = 1'b0; wr_light = 1'b0; wr_deep = 1'b0;
    cyc(BOTHV, "R3 both bits held");
    #2 rst_n = 1'b0;
    #1 check(RUNV, "R1 reset from deep");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(RUNV, "R1 run after reset");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule